// File: doc/BRIEF.md
# Quad-Channel Reset and Watchdog Supervisor

This block produces four active-low reset lines for four supervised supply rails. Each rail has an under-voltage flag and an over-voltage flag coming from external comparators. These flags are synchronized, reported on a status output at all times, and, when the rail's enable bit is set, used to pull that rail's reset low. Two causes are shared by all four outputs and pull every output low: a manual reset input, and a watchdog that expires when it sees no rising edge on its kick input. When a cause goes away, each output stays low for a further programmable time-out before it releases.

Configuration arrives as parallel inputs: a per-rail enable mask, a 2-bit reset time-out select, and a 2-bit watchdog period select. These values are captured only on clock edges where the manual reset input is low. The configuration agent therefore holds the outputs in reset while it updates the settings. The manual reset input is treated as synchronous to `clk`. The comparator flags and the watchdog kick input may be asynchronous, and each passes through two flip-flops.

Top module: `quad_reset_supervisor`

## Requirements
- R1: On the clock edge after `mr_n` is sampled low, all four `rst_n_out` bits are 0, whatever the enable mask and the rail flags.
- R2: After `mr_n` returns high, with no other cause present, every output stays 0 for exactly T clock edges and reads 1 from the T-th edge onward. T = 8 × 2^sel, where sel is the captured time-out select (0..3 gives 8, 16, 32 or 64).
- R3: A rising edge on `wdi` clears the watchdog count. The edge is seen on the third clock edge after the input change. With the default parameters and no later kick, the watchdog expires on the W-th edge after that clear. W = 32 × 2^sel, where sel is the captured watchdog select (0..3 gives 32, 64, 128 or 256).
- R4: If the watchdog is running and sees no rising edge for W edges, all four outputs go to 0 for T cycles. The watchdog then counts again from zero. This happens whether `wdi` is held at 1 or held at 0.
- R5: For rail i (bit i of every per-rail vector) with its enable bit set, either flag pulls only `rst_n_out[i]` low, three clock edges after the flag is driven high. After the flag drops, the output releases T+2 edges later.
- R6: For a rail whose enable bit is 0, its flags leave `rst_n_out` unchanged. `mon_fault[i]` still shows the OR of that rail's two synchronized flags.
- R7: `cfg_en`, `cfg_tmo_sel` and `cfg_wdt_sel` are captured only on edges where `mr_n` is low. Changes made while `mr_n` is high have no effect on resets or timing.
- R8: While `rst` is high, all outputs are 0. After `rst` falls they remain 0 for T0 = 8 cycles, because the default select is 0, and then release.
- R9: A new cause that arrives while an output is stretching restarts the count, so the output releases T edges after the last cause ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| mr_n | input | 1 | Manual reset, active low; also the configuration capture strobe |
| uv_flag | input | 4 | Per-rail under-voltage flags, asynchronous |
| ov_flag | input | 4 | Per-rail over-voltage flags, asynchronous |
| cfg_en | input | 4 | Per-rail reset enable mask to capture |
| cfg_tmo_sel | input | 2 | Reset time-out select to capture |
| cfg_wdt_sel | input | 2 | Watchdog period select to capture |
| wdi | input | 1 | Watchdog kick; only its rising edge counts |
| rst_n_out | output | 4 | Per-rail reset outputs, active low |
| mon_fault | output | 4 | Synchronized per-rail fault status, not masked by the enables |

## Verification
A wrong stretch counter shows up as an output that releases one or more edges too early or too late after its cause ends. The bench measures that release edge exactly for every time-out select, and again when a cause restarts the count. A watchdog count that is off, or that is cleared by a level instead of an edge, moves the first forced reset away from edge W. With a constant input it can also make the forced reset appear or disappear. This is checked for all four periods, with the input held at each level, and through the edge-exact result of a single kick. A wrong enable mask or a wrong capture rule shows as a rail that resets, or fails to reset, within three edges of its flag.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic {
    WD_RUN  = 1'b0,
    WD_HOLD = 1'b1
  } wd_state_e;

  // Cycle count for a 2-bit select applied to a base span.
  function automatic int unsigned span_cycles(input int unsigned base, input logic [1:0] sel);
    return base << sel;
  endfunction

endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cause,
  input  logic [CW-1:0] limit,
  output logic          rst_n_o
);

  logic          held;
  logic [CW-1:0] cnt;
  logic          release_now;

  assign release_now = held && !cause && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b1;
      cnt  <= '0;
    end else if (cause) begin
      held <= 1'b1;
      cnt  <= '0;
    end else if (release_now) begin
      held <= 1'b0;
    end else if (held) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign rst_n_o = ~held;

  // R2
  release_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> !$past(cause));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    cause |=> (!rst_n_o && cnt == '0));

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import sup_pkg::*;
#(
  parameter int unsigned WCW = 8,
  parameter int unsigned CW  = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run_ok,
  input  logic           kick,
  input  logic [WCW-1:0] wlimit,
  input  logic [CW-1:0]  hlimit,
  output logic           bite
);

  wd_state_e      st;
  logic [WCW-1:0] wcnt;
  logic [CW-1:0]  hcnt;

  assign bite = (st == WD_RUN) && run_ok && !kick && (wcnt == wlimit);

  always_ff @(posedge clk) begin
    if (rst || !run_ok) begin
      st   <= WD_RUN;
      wcnt <= '0;
      hcnt <= '0;
    end else begin
      case (st)
        WD_RUN: begin
          if (kick) begin
            wcnt <= '0;
          end else if (bite) begin
            st   <= WD_HOLD;
            wcnt <= '0;
            hcnt <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: begin
          if (hcnt == hlimit) begin
            st   <= WD_RUN;
            wcnt <= '0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R3
  kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (st == WD_RUN && kick) |=> (wcnt == '0));

  // R4
  bite_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bite |=> (st == WD_HOLD));

endmodule

// File: rtl/quad_reset_supervisor.sv
module quad_reset_supervisor
  import sup_pkg::*;
#(
  parameter int unsigned     NCH         = 4,
  parameter int unsigned     TMO_BASE    = 8,
  parameter int unsigned     WDT_BASE    = 32,
  parameter logic [NCH-1:0]  EN_RST      = '1,
  parameter logic [1:0]      TMO_SEL_RST = 2'd0,
  parameter logic [1:0]      WDT_SEL_RST = 2'd0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mr_n,
  input  logic [NCH-1:0] uv_flag,
  input  logic [NCH-1:0] ov_flag,
  input  logic [NCH-1:0] cfg_en,
  input  logic [1:0]     cfg_tmo_sel,
  input  logic [1:0]     cfg_wdt_sel,
  input  logic           wdi,
  output logic [NCH-1:0] rst_n_out,
  output logic [NCH-1:0] mon_fault
);

  localparam int unsigned TMO_MAX = TMO_BASE << 3;
  localparam int unsigned WDT_MAX = WDT_BASE << 3;
  localparam int unsigned CW      = $clog2(TMO_MAX);
  localparam int unsigned WCW     = $clog2(WDT_MAX);

  // Captured configuration
  logic [NCH-1:0] en_q;
  logic [1:0]     tmo_q;
  logic [1:0]     wdt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= EN_RST;
      tmo_q <= TMO_SEL_RST;
      wdt_q <= WDT_SEL_RST;
    end else if (!mr_n) begin
      en_q  <= cfg_en;
      tmo_q <= cfg_tmo_sel;
      wdt_q <= cfg_wdt_sel;
    end
  end

  logic [CW-1:0]  tmo_lim;
  logic [WCW-1:0] wdt_lim;
  assign tmo_lim = CW'(span_cycles(TMO_BASE, tmo_q) - 1);
  assign wdt_lim = WCW'(span_cycles(WDT_BASE, wdt_q) - 1);

  // Flag and kick synchronizers
  logic [2*NCH-1:0] flags_s;
  logic [NCH-1:0]   uv_s, ov_s;

  sup_sync2 #(.W(2*NCH)) u_flag_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ov_flag, uv_flag}),
    .q   (flags_s)
  );

  assign uv_s = flags_s[NCH-1:0];
  assign ov_s = flags_s[2*NCH-1:NCH];

  logic wdi_s, wdi_d, kick;

  sup_sync2 #(.W(1)) u_wdi_sync (
    .clk (clk),
    .rst (rst),
    .d   (wdi),
    .q   (wdi_s)
  );

  always_ff @(posedge clk) begin
    if (rst) wdi_d <= 1'b0;
    else     wdi_d <= wdi_s;
  end

  assign kick = wdi_s & ~wdi_d;

  // Watchdog
  logic bite;

  sup_wdog #(.WCW(WCW), .CW(CW)) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .run_ok (mr_n),
    .kick   (kick),
    .wlimit (wdt_lim),
    .hlimit (tmo_lim),
    .bite   (bite)
  );

  // Per-rail causes and stretchers
  logic [NCH-1:0] chan_fault;
  logic [NCH-1:0] cause;

  assign mon_fault  = uv_s | ov_s;
  assign chan_fault = en_q & mon_fault;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cause[i] = ~mr_n | bite | chan_fault[i];

    sup_stretch #(.CW(CW)) u_stretch (
      .clk     (clk),
      .rst     (rst),
      .cause   (cause[i]),
      .limit   (tmo_lim),
      .rst_n_o (rst_n_out[i])
    );

    // R5
    chan_fault_chk: assert property (@(posedge clk) disable iff (rst)
      chan_fault[i] |=> !rst_n_out[i]);
  end

  // R1
  mr_all_chk: assert property (@(posedge clk) disable iff (rst)
    !mr_n |=> (rst_n_out == '0));

  // R4
  bite_all_chk: assert property (@(posedge clk) disable iff (rst)
    bite |=> (rst_n_out == '0));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mr_n |=> ($stable(en_q) && $stable(tmo_q) && $stable(wdt_q)));

  // R8
  por_low_chk: assert property (@(posedge clk)
    $fell(rst) |-> (rst_n_out == '0));

endmodule

// File: tb/quad_reset_supervisor_tb.sv
module quad_reset_supervisor_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mr_n = 1'b1;
  logic [3:0] uv_flag = '0;
  logic [3:0] ov_flag = '0;
  logic [3:0] cfg_en = 4'hF;
  logic [1:0] cfg_tmo_sel = 2'd0;
  logic [1:0] cfg_wdt_sel = 2'd0;
  logic       wdi = 1'b0;
  logic [3:0] rst_n_out;
  logic [3:0] mon_fault;

  int checks = 0;
  int errors = 0;
  bit kick_en = 1'b1;
  int kc = 0;

  always #10 clk = ~clk;

  quad_reset_supervisor u_dut (
    .clk         (clk),
    .rst         (rst),
    .mr_n        (mr_n),
    .uv_flag     (uv_flag),
    .ov_flag     (ov_flag),
    .cfg_en      (cfg_en),
    .cfg_tmo_sel (cfg_tmo_sel),
    .cfg_wdt_sel (cfg_wdt_sel),
    .wdi         (wdi),
    .rst_n_out   (rst_n_out),
    .mon_fault   (mon_fault)
  );

  function automatic int tmo_of(input int sel);
    return 8 * (2 ** sel);
  endfunction

  function automatic int wdt_of(input int sel);
    return 32 * (2 ** sel);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Holds mr_n low for four cycles with new settings, returns at the release negedge.
  task automatic cfg_write(input logic [3:0] en, input logic [1:0] ts, input logic [1:0] ws);
    mr_n = 1'b0;
    cfg_en = en;
    cfg_tmo_sel = ts;
    cfg_wdt_sel = ws;
    step(1);
    check("R1 mr low forces all", rst_n_out, 4'h0);
    step(3);
    mr_n = 1'b1;
  endtask

  // Background kicker: a rising edge every 16 cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (kick_en) begin
        kc++;
        if (kc % 8 == 0) wdi = ~wdi;
      end
    end
  end

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t;
    int w;
    int bad;

    // R8: power-on
    step(3);
    check("R8 during reset", rst_n_out, 4'h0);
    rst = 1'b0;
    step(7);
    check("R8 stretch after reset", rst_n_out, 4'h0);
    step(1);
    check("R8 release after reset", rst_n_out, 4'hF);

    // R2: stretch length for every time-out select
    for (int ts = 0; ts < 4; ts++) begin
      t = tmo_of(ts);
      cfg_write(4'hF, 2'(ts), 2'd3);
      step(t - 1);
      check("R2 last low edge", rst_n_out, 4'h0);
      step(1);
      check("R2 release edge", rst_n_out, 4'hF);
    end

    // R9: second manual pulse during stretch restarts the count
    cfg_write(4'hF, 2'd0, 2'd3);
    step(4);
    check("R9 mid stretch", rst_n_out, 4'h0);
    mr_n = 1'b0;
    step(1);
    mr_n = 1'b1;
    step(7);
    check("R9 restarted low", rst_n_out, 4'h0);
    step(1);
    check("R9 restarted release", rst_n_out, 4'hF);

    // R5: each rail, each flag kind
    t = 8;
    for (int ch = 0; ch < 4; ch++) begin
      for (int kind = 0; kind < 2; kind++) begin
        if (kind == 0) uv_flag[ch] = 1'b1;
        else           ov_flag[ch] = 1'b1;
        step(2);
        check("R5 not yet asserted", rst_n_out, 4'hF);
        check("R6 monitor follows flag", mon_fault, 4'(1 << ch));
        step(1);
        check("R5 own rail only", rst_n_out, ~4'(1 << ch));
        uv_flag = '0;
        ov_flag = '0;
        step(t + 1);
        check("R5 still low after clear", rst_n_out, ~4'(1 << ch));
        step(1);
        check("R5 release after clear", rst_n_out, 4'hF);
      end
    end

    // R6: disabled rail ignores flags but still reports them
    cfg_write(4'hE, 2'd0, 2'd3);
    step(8);
    uv_flag[0] = 1'b1;
    ov_flag[0] = 1'b1;
    step(6);
    check("R6 disabled rail ignored", rst_n_out, 4'hF);
    check("R6 monitor active when disabled", mon_fault, 4'h1);
    uv_flag = '0;
    ov_flag = '0;
    step(3);
    check("R6 monitor clears", mon_fault, 4'h0);

    // R7: settings changed with mr_n high are ignored
    cfg_en = 4'h0;
    cfg_tmo_sel = 2'd3;
    uv_flag[1] = 1'b1;
    step(3);
    check("R7 old enable still used", rst_n_out, 4'hD);
    uv_flag = '0;
    step(9);
    check("R7 old time-out low", rst_n_out, 4'hD);
    step(1);
    check("R7 old time-out release", rst_n_out, 4'hF);
    uv_flag[0] = 1'b1;
    step(6);
    check("R7 rail0 still disabled", rst_n_out, 4'hF);
    uv_flag = '0;
    step(3);

    // R4: expiry for each period, input held low and held high
    kick_en = 1'b0;
    for (int ws = 0; ws < 4; ws++) begin
      for (int lvl = 0; lvl < 2; lvl++) begin
        w = wdt_of(ws);
        wdi = lvl[0];
        cfg_write(4'hF, 2'd0, 2'(ws));
        step(w - 1);
        check("R4 before expiry", rst_n_out, 4'hF);
        step(1);
        check("R4 expiry forces all", rst_n_out, 4'h0);
        step(7);
        check("R4 expiry stretch low", rst_n_out, 4'h0);
        step(1);
        check("R4 expiry release", rst_n_out, 4'hF);
        step(w - 1);
        check("R4 restarted before expiry", rst_n_out, 4'hF);
        step(1);
        check("R4 second expiry", rst_n_out, 4'h0);
      end
    end

    // R3: one kick moves the expiry to exactly W edges after it is seen
    wdi = 1'b0;
    cfg_write(4'hF, 2'd0, 2'd0);
    step(10);
    wdi = 1'b1;
    step(34);
    check("R3 kick postponed expiry", rst_n_out, 4'hF);
    step(1);
    check("R3 expiry after kick", rst_n_out, 4'h0);

    // R3: steady kicking prevents expiry
    wdi = 1'b0;
    kick_en = 1'b1;
    cfg_write(4'hF, 2'd0, 2'd0);
    step(8);
    bad = 0;
    for (int i = 0; i < 400; i++) begin
      step(1);
      if (rst_n_out !== 4'hF) bad++;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R3 kicked watchdog: actual %0d low samples expected 0", bad);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule